// File: doc/BRIEF.md
# Inter-Processor Interrupt Controller

This block lets a group of processor agents signal one another over a shared register bus. Each agent owns a bank of six registers and a fixed one-hot bit position. That bit names the agent in every bank. To notify peers, an agent writes a word holding their bits into its own send register. Each target then sees the sender's bit in its pending-status register. While a notification is outstanding, the sender sees the target's bit in its outstanding register. When the target clears the bit in its status register with a write-one-to-clear, the sender's outstanding bit drops in the same clock. A sender can therefore poll its outstanding register until the bit reads zero.

Each agent has a mask that is set after reset and changed only through separate unmask and mask-set strobe registers. Each agent has one interrupt output: the OR of its pending bits that are not masked. Several bus ports can access the banks in the same cycle. Every request names the local agent and carries a secure flag. Requests are checked for range first and for permission second. A rejected request changes no state.

Top module: `ipi_ctrl`

## Requirements
- R1: Register offsets inside a bank are: send 0x00, outstanding 0x04, pending-status 0x10, mask 0x14, unmask strobe 0x18, mask-set strobe 0x1C. Any other offset is rejected with code 1. Every request gets a response exactly one clock later, with code 0 = accepted, 1 = invalid argument, 2 = permission denied. A read returns the register value from before that clock's writes. Reads of the send and strobe registers return zero, and rejected requests return zero data.
- R2: Agents 0..10 sit at word bits 0, 8, 9, 16, 17, 18, 19, 24, 25, 26 and 27, in that order. Every register word uses this layout, and all other bits read as zero.
- R3: An accepted write of word D to agent A's send register sets bit(A) in the pending-status of every agent B whose bit is set in D. In the same clock, bit(B) is set in A's outstanding register. Pending bits change only through send writes and status clears.
- R4: An accepted write of word D to agent B's pending-status register clears each bit(A) set in D, and clears bit(B) in A's outstanding register. Bits written as zero are left unchanged.
- R5: The mask is all set after reset. A write to the unmask strobe clears the written bits, and a write to the mask-set strobe sets them. Zero bits are left unchanged. If the same bit is unmasked and mask-set in one clock, it ends up masked. Writes to the mask and outstanding registers are accepted but change nothing.
- R6: The interrupt output of agent X is high exactly when some pending bit of X is unmasked. Pending bits still latch while masked.
- R7: A request is rejected with code 1 and has no effect if any of these holds: the local agent index is 11 or more, the offset is unknown, or the write data has a bit outside the agent bits. This check takes precedence over the permission check.
- R8: Agents 3, 5 and 6 (bits 16, 18, 19) are secure-only. A non-secure request is rejected with code 2 and has no effect if its local agent is secure-only, or if it is a write whose data names a secure-only agent.
- R9: If a send and a clear hit the same pending bit in one clock, through different ports, the bit ends up set.
- R10: While reset is high, all pending and outstanding bits clear, every mask bit sets, and the interrupt outputs and response valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_PORTS | Request strobe per port |
| req_write | input | NUM_PORTS | 1 = write, 0 = read |
| req_secure | input | NUM_PORTS | Requester is secure |
| req_agent | input | NUM_PORTS*4 | Local agent index per port |
| req_addr | input | NUM_PORTS*8 | Byte offset inside the bank |
| req_wdata | input | NUM_PORTS*32 | Write data per port |
| rsp_valid | output | NUM_PORTS | Response strobe, one clock after the request |
| rsp_code | output | NUM_PORTS*2 | Result code per port |
| rsp_rdata | output | NUM_PORTS*32 | Read data per port |
| irq | output | NUM_AGENTS | Interrupt line per agent |

## Verification
The bench drives directed sequences and random traffic on both ports, and compares every response and every interrupt line against a behavioural model on each clock.

A wrong pending bit shows up at the affected agent's interrupt line in the same clock in which the state settles, provided that source is unmasked. It also shows up in the read data the next time either side reads its status or outstanding word. A bad mask bit appears the same way, on the interrupt line or on a read of the mask word. A wrong precedence or a wrong permission decision shows up in the response code one clock after the request.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int WORD_W     = 32;
    localparam int ADDR_W     = 8;
    localparam int IDX_W      = 4;
    localparam int MAX_AGENTS = 11;
    localparam int CODE_W     = 2;

    typedef logic [MAX_AGENTS-1:0] agent_vec_t;
    typedef logic [WORD_W-1:0]     word_t;

    typedef enum logic [2:0] {
        SEL_SEND,
        SEL_OUTST,
        SEL_PEND,
        SEL_MASK,
        SEL_UNMASK,
        SEL_MASKSET,
        SEL_BAD
    } reg_sel_e;

    typedef enum logic [CODE_W-1:0] {
        CODE_OK    = 2'd0,
        CODE_INVAL = 2'd1,
        CODE_PERM  = 2'd2
    } rsp_code_e;

    typedef struct packed {
        logic             act;     // accepted write
        logic             rd;      // accepted read
        reg_sel_e         sel;
        logic [IDX_W-1:0] agent;
        agent_vec_t       targets;
        rsp_code_e        code;
    } cmd_t;

    // Word bit owned by agent idx: classes of 1, 2, 4 and 4 agents
    function automatic logic [4:0] agent_bit(input int idx);
        int pos;
        if (idx < 1)      pos = idx;
        else if (idx < 3) pos = idx + 7;
        else if (idx < 7) pos = idx + 13;
        else              pos = idx + 17;
        return pos[4:0];
    endfunction

    function automatic word_t agents_word(input int n);
        word_t w;
        w = '0;
        for (int i = 0; i < MAX_AGENTS; i++)
            if (i < n) w[agent_bit(i)] = 1'b1;
        return w;
    endfunction

    function automatic agent_vec_t word_to_vec(input word_t w);
        agent_vec_t v;
        for (int i = 0; i < MAX_AGENTS; i++) v[i] = w[agent_bit(i)];
        return v;
    endfunction

    function automatic word_t vec_to_word(input agent_vec_t v);
        word_t w;
        w = '0;
        for (int i = 0; i < MAX_AGENTS; i++) w[agent_bit(i)] = v[i];
        return w;
    endfunction

    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
        case (a)
            8'h00:   return SEL_SEND;
            8'h04:   return SEL_OUTST;
            8'h10:   return SEL_PEND;
            8'h14:   return SEL_MASK;
            8'h18:   return SEL_UNMASK;
            8'h1C:   return SEL_MASKSET;
            default: return SEL_BAD;
        endcase
    endfunction

endpackage

// File: rtl/ipi_req_check.sv
module ipi_req_check
    import ipi_pkg::*;
#(
    parameter int          NUM_AGENTS  = 11,
    parameter logic [31:0] SECURE_WORD = 32'h000D_0000
) (
    input  logic              valid,
    input  logic              write,
    input  logic              secure,
    input  logic [IDX_W-1:0]  agent,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             wdata,
    output cmd_t              cmd
);
    localparam word_t            LIVE_WORD = agents_word(NUM_AGENTS);
    localparam word_t            SEC_WORD  = SECURE_WORD & LIVE_WORD;
    localparam logic [IDX_W-1:0] AGENT_LIM = IDX_W'(NUM_AGENTS);

    reg_sel_e sel;
    logic     in_range, local_sec, remote_bad, remote_sec;

    always_comb begin
        sel        = decode_offset(addr);
        in_range   = (agent < AGENT_LIM);
        local_sec  = in_range && SEC_WORD[agent_bit(int'(agent))];
        remote_bad = write && ((wdata & ~LIVE_WORD) != '0);
        remote_sec = write && ((wdata & SEC_WORD) != '0);

        cmd         = '0;
        cmd.sel     = sel;
        cmd.agent   = agent;
        cmd.targets = word_to_vec(wdata);
        // range and decoding come before the permission check
        if (!in_range || sel == SEL_BAD || remote_bad)
            cmd.code = CODE_INVAL;
        else if (!secure && (local_sec || remote_sec))
            cmd.code = CODE_PERM;
        else
            cmd.code = CODE_OK;
        cmd.act = valid && write && (cmd.code == CODE_OK);
        cmd.rd  = valid && !write && (cmd.code == CODE_OK);
    end
endmodule

// File: rtl/ipi_agent_bank.sv
module ipi_agent_bank
    import ipi_pkg::*;
#(
    parameter int NUM_AGENTS = 11
) (
    input  logic       clk,
    input  logic       rst,
    input  agent_vec_t set_i,
    input  agent_vec_t clr_i,
    input  agent_vec_t unmask_i,
    input  agent_vec_t maskset_i,
    output agent_vec_t pend_o,
    output agent_vec_t mask_o,
    output logic       irq_o
);
    localparam agent_vec_t LIVE = agent_vec_t'((32'd1 << NUM_AGENTS) - 32'd1);

    agent_vec_t pend_q, mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            mask_q <= LIVE;
        end else begin
            // a send beats a clear on the same bit
            pend_q <= (set_i | (pend_q & ~clr_i)) & LIVE;
            // mask-set beats unmask on the same bit
            mask_q <= ((mask_q & ~unmask_i) | maskset_i) & LIVE;
        end
    end

    assign pend_o = pend_q;
    assign mask_o = mask_q;
    assign irq_o  = |(pend_q & ~mask_q);

    // R9
    send_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((pend_q & $past(set_i & LIVE)) == $past(set_i & LIVE)));

    // R4
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        ((clr_i & ~set_i) != '0) |=> ((pend_q & $past(clr_i & ~set_i)) == '0));

    // R3
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (set_i == '0 && clr_i == '0) |=> $stable(pend_q));

    // R5
    maskset_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (maskset_i != '0) |=> ((mask_q & $past(maskset_i & LIVE)) == $past(maskset_i & LIVE)));

    // R10
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (pend_q == '0 && mask_q == LIVE));
endmodule

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
    import ipi_pkg::*;
#(
    parameter int          NUM_AGENTS  = 11,
    parameter int          NUM_PORTS   = 2,
    parameter logic [31:0] SECURE_WORD = 32'h000D_0000
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_PORTS-1:0]          req_valid,
    input  logic [NUM_PORTS-1:0]          req_write,
    input  logic [NUM_PORTS-1:0]          req_secure,
    input  logic [NUM_PORTS*IDX_W-1:0]    req_agent,
    input  logic [NUM_PORTS*ADDR_W-1:0]   req_addr,
    input  logic [NUM_PORTS*WORD_W-1:0]   req_wdata,
    output logic [NUM_PORTS-1:0]          rsp_valid,
    output logic [NUM_PORTS*CODE_W-1:0]   rsp_code,
    output logic [NUM_PORTS*WORD_W-1:0]   rsp_rdata,
    output logic [NUM_AGENTS-1:0]         irq
);
    cmd_t       cmd      [NUM_PORTS];
    agent_vec_t set_v    [NUM_AGENTS];
    agent_vec_t clr_v    [NUM_AGENTS];
    agent_vec_t unmask_v [NUM_AGENTS];
    agent_vec_t mset_v   [NUM_AGENTS];
    agent_vec_t pend_v   [NUM_AGENTS];
    agent_vec_t mask_v   [NUM_AGENTS];
    agent_vec_t outst_v  [NUM_AGENTS];

    // request checking, one per port
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        ipi_req_check #(
            .NUM_AGENTS (NUM_AGENTS),
            .SECURE_WORD(SECURE_WORD)
        ) u_chk (
            .valid (req_valid[p]),
            .write (req_write[p]),
            .secure(req_secure[p]),
            .agent (req_agent[p*IDX_W +: IDX_W]),
            .addr  (req_addr[p*ADDR_W +: ADDR_W]),
            .wdata (req_wdata[p*WORD_W +: WORD_W]),
            .cmd   (cmd[p])
        );
    end

    // cross-linking of banks: a send lands in the receivers' banks
    always_comb begin
        for (int x = 0; x < NUM_AGENTS; x++) begin
            set_v[x]    = '0;
            clr_v[x]    = '0;
            unmask_v[x] = '0;
            mset_v[x]   = '0;
        end
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (cmd[p].act) begin
                case (cmd[p].sel)
                    SEL_SEND: begin
                        for (int x = 0; x < NUM_AGENTS; x++)
                            if (cmd[p].targets[x]) set_v[x][cmd[p].agent] = 1'b1;
                    end
                    SEL_PEND:    clr_v[cmd[p].agent]    = clr_v[cmd[p].agent]    | cmd[p].targets;
                    SEL_UNMASK:  unmask_v[cmd[p].agent] = unmask_v[cmd[p].agent] | cmd[p].targets;
                    SEL_MASKSET: mset_v[cmd[p].agent]   = mset_v[cmd[p].agent]   | cmd[p].targets;
                    default: ;
                endcase
            end
        end
    end

    for (genvar x = 0; x < NUM_AGENTS; x++) begin : g_bank
        ipi_agent_bank #(
            .NUM_AGENTS(NUM_AGENTS)
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .set_i    (set_v[x]),
            .clr_i    (clr_v[x]),
            .unmask_i (unmask_v[x]),
            .maskset_i(mset_v[x]),
            .pend_o   (pend_v[x]),
            .mask_o   (mask_v[x]),
            .irq_o    (irq[x])
        );
    end

    // outstanding view: bit b of agent a mirrors pending bit a of agent b
    always_comb begin
        for (int a = 0; a < NUM_AGENTS; a++) begin
            outst_v[a] = '0;
            for (int b = 0; b < NUM_AGENTS; b++) outst_v[a][b] = pend_v[b][a];
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rsp
        word_t       rd_word, rdata_q;
        logic        valid_q;
        logic [1:0]  code_q;

        always_comb begin
            rd_word = '0;
            if (cmd[p].rd) begin
                case (cmd[p].sel)
                    SEL_OUTST: rd_word = vec_to_word(outst_v[cmd[p].agent]);
                    SEL_PEND:  rd_word = vec_to_word(pend_v[cmd[p].agent]);
                    SEL_MASK:  rd_word = vec_to_word(mask_v[cmd[p].agent]);
                    default:   rd_word = '0;
                endcase
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q <= 1'b0;
                code_q  <= CODE_OK;
                rdata_q <= '0;
            end else begin
                valid_q <= req_valid[p];
                code_q  <= req_valid[p] ? cmd[p].code : CODE_OK;
                rdata_q <= rd_word;
            end
        end

        assign rsp_valid[p]                  = valid_q;
        assign rsp_code[p*CODE_W +: CODE_W]  = code_q;
        assign rsp_rdata[p*WORD_W +: WORD_W] = rdata_q;

        // R1
        rsp_latency_chk: assert property (@(posedge clk) disable iff (rst)
            req_valid[p] |=> rsp_valid[p]);

        // R1
        rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
            !req_valid[p] |=> !rsp_valid[p]);

        // R7
        reject_data_chk: assert property (@(posedge clk) disable iff (rst)
            (rsp_valid[p] && rsp_code[p*CODE_W +: CODE_W] != CODE_OK)
                |-> (rsp_rdata[p*WORD_W +: WORD_W] == '0));

        // R8
        secure_no_perm_chk: assert property (@(posedge clk) disable iff (rst)
            (req_valid[p] && req_secure[p])
                |=> (rsp_code[p*CODE_W +: CODE_W] != CODE_PERM));
    end
endmodule

// File: tb/ipi_ctrl_test.sv
module ipi_ctrl_test;
    localparam int NA = 11;
    localparam int NP = 2;
    localparam logic [31:0] VALID = 32'h0F0F_0301;
    localparam logic [31:0] SEC   = 32'h000D_0000;

    int POS [NA] = '{0, 8, 9, 16, 17, 18, 19, 24, 25, 26, 27};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NP-1:0] v = '0, w = '0, s = '0;
    logic [3:0]  ag [NP];
    logic [7:0]  ad [NP];
    logic [31:0] wd [NP];

    logic [NP*4-1:0]  ag_f;
    logic [NP*8-1:0]  ad_f;
    logic [NP*32-1:0] wd_f;
    logic [NP-1:0]    rsp_valid;
    logic [NP*2-1:0]  rsp_code;
    logic [NP*32-1:0] rsp_rdata;
    logic [NA-1:0]    irq;

    assign ag_f = {ag[1], ag[0]};
    assign ad_f = {ad[1], ad[0]};
    assign wd_f = {wd[1], wd[0]};

    ipi_ctrl uut (
        .clk(clk), .rst(rst),
        .req_valid(v), .req_write(w), .req_secure(s),
        .req_agent(ag_f), .req_addr(ad_f), .req_wdata(wd_f),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_rdata(rsp_rdata),
        .irq(irq)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    logic [31:0] m_pend [NA];
    logic [31:0] m_mask [NA];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit known_off(input logic [7:0] off);
        return off == 8'h00 || off == 8'h04 || off == 8'h10 ||
               off == 8'h14 || off == 8'h18 || off == 8'h1C;
    endfunction

    function automatic logic [31:0] model_read(input int a, input logic [7:0] off);
        logic [31:0] r = '0;
        if (off == 8'h04) begin
            for (int b = 0; b < NA; b++) if (m_pend[b][POS[a]]) r[POS[b]] = 1'b1;
        end else if (off == 8'h10) r = m_pend[a];
        else if (off == 8'h14)     r = m_mask[a];
        return r;
    endfunction

    function automatic string auto_tag(input int code, input bit wr, input logic [7:0] off);
        if (code == 1) return "R7";
        if (code == 2) return "R8";
        if (!wr)       return "R1";
        if (off == 8'h00) return "R3";
        if (off == 8'h10) return "R4";
        return "R5";
    endfunction

    task automatic put(input int p, input bit wr, input bit sec, input int a,
                       input logic [7:0] off, input logic [31:0] d);
        v[p] = 1'b1; w[p] = wr; s[p] = sec;
        ag[p] = 4'(a); ad[p] = off; wd[p] = d;
    endtask

    // one clock: predict, advance the model, then compare at the falling edge
    task automatic step(input string tag_in);
        bit          ev [NP];
        int          ec [NP];
        logic [31:0] er [NP];
        string       tg [NP];
        logic [31:0] np [NA];
        logic [31:0] nm [NA];
        int          a;
        for (int p = 0; p < NP; p++) begin
            ev[p] = v[p]; ec[p] = 0; er[p] = '0;
            a = int'(ag[p]);
            if (v[p]) begin
                if (a >= NA || !known_off(ad[p]) || (w[p] && (wd[p] & ~VALID) != 0))
                    ec[p] = 1;
                else if (!s[p] && (SEC[POS[a]] || (w[p] && (wd[p] & SEC) != 0)))
                    ec[p] = 2;
                else if (!w[p])
                    er[p] = model_read(a, ad[p]);
            end
            tg[p] = (tag_in != "") ? tag_in : auto_tag(ec[p], w[p], ad[p]);
        end
        for (int x = 0; x < NA; x++) begin np[x] = m_pend[x]; nm[x] = m_mask[x]; end
        for (int p = 0; p < NP; p++)
            if (v[p] && w[p] && ec[p] == 0) begin
                a = int'(ag[p]);
                if (ad[p] == 8'h10) np[a] = np[a] & ~wd[p];
                if (ad[p] == 8'h18) nm[a] = nm[a] & ~wd[p];
            end
        for (int p = 0; p < NP; p++)
            if (v[p] && w[p] && ec[p] == 0) begin
                a = int'(ag[p]);
                if (ad[p] == 8'h1C) nm[a] = nm[a] | wd[p];
                if (ad[p] == 8'h00)
                    for (int b = 0; b < NA; b++)
                        if (wd[p][POS[b]]) np[b][POS[a]] = 1'b1;
            end
        @(posedge clk);
        for (int x = 0; x < NA; x++) begin m_pend[x] = np[x]; m_mask[x] = nm[x]; end
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            chk(rsp_valid[p] == ev[p], tg[p], 32'(rsp_valid[p]), 32'(ev[p]));
            if (ev[p]) begin
                chk(int'(rsp_code[p*2 +: 2]) == ec[p], tg[p], 32'(rsp_code[p*2 +: 2]), 32'(ec[p]));
                chk(rsp_rdata[p*32 +: 32] == er[p], tg[p], rsp_rdata[p*32 +: 32], er[p]);
            end
        end
        for (int x = 0; x < NA; x++) begin
            bit ei = ((m_pend[x] & ~m_mask[x]) != 0);
            chk(irq[x] == ei, (tag_in != "") ? tag_in : "R6", 32'(irq[x]), 32'(ei));
        end
        v = '0;
    endtask

    task automatic rand_req(input int p);
        logic [7:0] offs [7] = '{8'h00, 8'h04, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h08};
        logic [31:0] d;
        d = $urandom & $urandom & VALID;
        if ($urandom % 16 == 0) d = d | (32'h1 << ($urandom % 32));
        v[p] = ($urandom % 4) != 0;
        w[p] = ($urandom % 3) != 0;
        s[p] = ($urandom % 4) != 0;
        ag[p] = 4'($urandom % 13);
        ad[p] = offs[$urandom % 7];
        wd[p] = d;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        for (int p = 0; p < NP; p++) begin ag[p] = '0; ad[p] = '0; wd[p] = '0; end
        for (int x = 0; x < NA; x++) begin m_pend[x] = '0; m_mask[x] = VALID & (32'h1 << POS[x]) | VALID; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: state during reset
        chk(rsp_valid == '0, "R10", 32'(rsp_valid), 32'h0);
        chk(irq == '0, "R10", 32'(irq), 32'h0);
        rst = 1'b0;

        // R10 / R2: mask word after reset
        put(0, 0, 1, 0, 8'h14, 0); put(1, 0, 1, 10, 8'h14, 0); step("R10");
        // R3: agent 0 sends to agent 1
        put(0, 1, 0, 0, 8'h00, 32'h0000_0100); step("R3");
        put(0, 0, 0, 0, 8'h04, 0); put(1, 0, 0, 1, 8'h10, 0); step("R3");
        // R1: send and strobe registers read zero, read returns pre-write value
        put(0, 0, 1, 0, 8'h00, 0); put(1, 0, 1, 1, 8'h18, 0); step("R1");
        // R6: still masked, then unmask
        step("R6");
        put(0, 1, 0, 1, 8'h18, 32'h0000_0001); step("R6");
        // R4: receiver clears, sender's outstanding bit drops
        put(0, 1, 0, 1, 8'h10, 32'h0000_0001); step("R4");
        put(0, 0, 0, 0, 8'h04, 0); put(1, 0, 0, 1, 8'h10, 0); step("R4");
        // R9: send and clear on the same bit in one clock
        put(0, 1, 0, 0, 8'h00, 32'h0000_0100); step("R9");
        put(0, 1, 0, 1, 8'h10, 32'h0000_0001); put(1, 1, 0, 0, 8'h00, 32'h0000_0100); step("R9");
        put(0, 0, 0, 1, 8'h10, 0); step("R9");
        // R7: bad index, bad offset, bad data bit, precedence over permission
        put(0, 0, 1, 11, 8'h10, 0); put(1, 0, 1, 0, 8'h08, 0); step("R7");
        put(0, 1, 1, 0, 8'h00, 32'h0000_0002); put(1, 0, 0, 3, 8'h0C, 0); step("R7");
        // R8: non-secure to secure agents, then a secure sender works
        put(0, 0, 0, 3, 8'h10, 0); put(1, 1, 0, 0, 8'h00, 32'h0001_0000); step("R8");
        put(0, 0, 1, 3, 8'h10, 0); put(1, 0, 0, 4, 8'h10, 0); step("R8");
        put(0, 1, 1, 0, 8'h00, 32'h0001_0000); step("R8");
        // R5: unmask and mask-set on the same bit, writes to mask ignored
        put(0, 1, 1, 2, 8'h18, 32'h0000_0001); put(1, 1, 1, 2, 8'h1C, 32'h0000_0001); step("R5");
        put(0, 1, 1, 2, 8'h14, 32'h0); put(1, 1, 1, 0, 8'h04, 32'h0); step("R5");
        put(0, 0, 1, 2, 8'h14, 0); put(1, 0, 1, 0, 8'h04, 0); step("R5");
        // R2: highest class agent sends to agents 6 and 7
        put(0, 1, 1, 10, 8'h00, 32'h0100_0000 | 32'h0008_0000); step("R2");
        put(0, 0, 1, 6, 8'h10, 0); put(1, 0, 1, 10, 8'h04, 0); step("R2");

        for (int n = 0; n < 3000; n++) begin
            rand_req(0);
            rand_req(1);
            step("");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule